// File: doc/BRIEF.md
# NAND Page Parity Accumulator

This block generates single-error-correcting parity for data moving between a flash controller and its NAND devices. It keeps four independent contexts, one per chipselect. A context watches the 8-bit bytes that are tagged with its chipselect, but only while two conditions hold: the context has been armed by a start command, and the chipselect has been placed in NAND mode. Over one 512-byte chunk it builds two 12-bit parity groups. Each data bit has a 12-bit position, formed from the 9-bit byte index followed by the 3-bit bit index. The high group XORs together every data bit whose position bit k is 1. The low group XORs together every data bit whose position bit k is 0.

Software reaches the block through a small word-addressed register port. Word 0 is the control register. It holds the NAND-mode bits and accepts start commands. Words 4 to 7 are the result words for chipselects 0 to 3. Reading a result word returns the parity and clears that context in the same cycle. The intended flow per chunk is: start the chipselect, move 512 bytes, read the result. Software then stores the inverted 24-bit value {high, low}, packed low byte first. With this scheme an erased chunk of all 0xFF carries a stored code of 0xFFFFFF.

Top module: `nand_page_parity`

## Requirements
- R1: After reset, all NAND-mode bits are 0, every context is disarmed, and every result word and the control word read as zero.
- R2: Writing word 0 loads the NAND-mode bits from write-data bits [3:0]. Reading word 0 returns those bits in [3:0] and zero everywhere else, so start bits always read back as 0.
- R3: Writing word 0 with bit 8+cs set clears the parity and byte count of context cs and arms it. Contexts whose start bit is 0 are left unchanged.
- R4: A byte is taken into context cs only if all of these hold: byte_valid is high, byte_cs equals cs, NAND-mode bit cs is 1, and context cs is armed. Any other byte leaves the result unchanged.
- R5: The k-th accepted byte of a chunk has index k. Data bit j of that byte has position {k[8:0], j[2:0]}. High-group bit n is the XOR of all accepted data bits whose position bit n is 1. Low-group bit n is the XOR of all accepted data bits whose position bit n is 0.
- R6: The result word for chipselect cs sits at word address 4+cs. It carries the low group in bits [11:0] and the high group in bits [27:16]. All other bits are zero.
- R7: Read data appears on reg_rdata in the cycle after reg_rd_en. A result read also clears that context's parity and count and disarms it, so a second read returns zero.
- R8: A full chunk of 512 bytes of 0xFF produces a result word of zero.
- R9: Once 512 bytes have been accepted, further bytes for that context are ignored until the next start.
- R10: Flipping one data bit at byte i, bit j changes the result so that the high-group difference equals {i, j} and the low-group difference is its complement.
- R11: A byte for chipselect cs that arrives in the same cycle as a start or a result read of cs is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address (0 control, 4+cs result) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd_en |
| byte_valid | input | 1 | A data byte is on the flash bus this cycle |
| byte_cs | input | 2 | Chipselect that owns the byte |
| byte_data | input | 8 | Data byte |

## Verification
Some events are hard to bring about from the ports. A start command or a result read must land in exactly the cycle a byte is offered for the same chipselect, and a context must be pushed past its 512-byte limit. The bench drives the register strobe and the byte strobe on the same clock edge, then checks that the dropped byte is absent from the following chunk's parity. It also streams 520 bytes and compares the result against a model that covers only the first 512. For single-bit flips, the bench compares two chunks that differ in one chosen bit and decodes the difference of the two result words back into the flipped position.

// File: rtl/npp_pkg.sv
// Package: shared constants and the result-word packing helper for the
// NAND page parity accumulator.
package npp_pkg;
    localparam int CTRL_MODE_LSB  = 0;   // NAND-mode bits start here
    localparam int CTRL_START_LSB = 8;   // start bit for cs is at this + cs
    localparam int HALF_W         = 16;  // high group begins at this bit

    // Pack the two parity groups into a 32-bit result word.
    function automatic logic [31:0] pack_result(input logic [11:0] hi,
                                                input logic [11:0] lo);
        logic [31:0] w;
        w = '0;
        w[11:0]                 = lo;
        w[HALF_W+11:HALF_W]     = hi;
        return w;
    endfunction
endpackage

// File: rtl/npp_byte_syndrome.sv
// Module: npp_byte_syndrome
// Computes, with no state, what one byte adds to the high and low parity
// groups, given its index inside the chunk.
// Assumes: the position of bit j of byte i is {i, j}, and GRP_W = IDX_W + 3.
module npp_byte_syndrome #(
    parameter int IDX_W = 9,
    localparam int GRP_W = IDX_W + 3
) (
    input  logic [7:0]       data_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [GRP_W-1:0] hi_o,
    output logic [GRP_W-1:0] lo_o
);
    logic byte_par;
    assign byte_par = ^data_i;

    for (genvar n = 0; n < GRP_W; n++) begin : g_bit
        if (n < 3) begin : g_in_byte
            // Bit-index groups: split the byte by bit n of the bit index.
            logic [7:0] sel;
            always_comb begin
                for (int j = 0; j < 8; j++) begin
                    sel[j] = ((j >> n) & 1) == 1;
                end
            end
            assign hi_o[n] = ^(data_i & sel);
            assign lo_o[n] = ^(data_i & ~sel);
        end else begin : g_by_idx
            // Byte-index groups: the whole byte parity goes to one side.
            assign hi_o[n] = idx_i[n-3]  & byte_par;
            assign lo_o[n] = ~idx_i[n-3] & byte_par;
        end
    end
endmodule

// File: rtl/npp_context.sv
// Module: npp_context
// Holds the parity state of one chipselect: an armed flag, a saturating
// byte count and the two parity groups.
// Assumes: start and clear are single-cycle strobes. Start takes priority
// over clear, and both take priority over a byte in the same cycle.
module npp_context #(
    parameter int CHUNK_BYTES = 512,
    localparam int IDX_W = $clog2(CHUNK_BYTES),
    localparam int GRP_W = IDX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             clear_i,
    input  logic             byte_en_i,
    input  logic [7:0]       data_i,
    output logic [GRP_W-1:0] hi_o,
    output logic [GRP_W-1:0] lo_o
);
    logic             armed_q;
    logic [IDX_W:0]   cnt_q;
    logic [GRP_W-1:0] hi_q, lo_q;
    logic [GRP_W-1:0] hi_add, lo_add;
    logic             take;

    npp_byte_syndrome #(.IDX_W(IDX_W)) u_syn (
        .data_i (data_i),
        .idx_i  (cnt_q[IDX_W-1:0]),
        .hi_o   (hi_add),
        .lo_o   (lo_add)
    );

    // Accept a byte only if armed, below the chunk limit and not overridden.
    assign take = byte_en_i && armed_q && (cnt_q < (IDX_W+1)'(CHUNK_BYTES))
                  && !start_i && !clear_i;

    // Context state update: start, clear-on-read, or accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (start_i) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (clear_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            hi_q  <= hi_q ^ hi_add;
            lo_q  <= lo_q ^ lo_add;
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (IDX_W+1)'(CHUNK_BYTES));

    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0 && hi_q == '0 && lo_q == '0 && armed_q));

    // R7
    clear_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !start_i) |=> (!armed_q && hi_q == '0 && lo_q == '0));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !start_i && !clear_i) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/nand_page_parity.sv
// Module: nand_page_parity
// Top level: decodes the register port, gates incoming bytes per chipselect
// by NAND-mode bit and chipselect match, and returns control or result words.
// Assumes: NUM_CS is a power of two no larger than 8, and word addresses
// NUM_CS .. 2*NUM_CS-1 hold the result words.
module nand_page_parity #(
    parameter int NUM_CS      = 4,
    parameter int CHUNK_BYTES = 512,
    localparam int CS_W   = $clog2(NUM_CS),
    localparam int ADDR_W = CS_W + 1,
    localparam int IDX_W  = $clog2(CHUNK_BYTES),
    localparam int GRP_W  = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              byte_valid,
    input  logic [CS_W-1:0]   byte_cs,
    input  logic [7:0]        byte_data
);
    import npp_pkg::*;

    logic [NUM_CS-1:0] mode_q;
    logic [NUM_CS-1:0] start_s, clear_s, en_s;
    logic [GRP_W-1:0]  hi_s [NUM_CS];
    logic [GRP_W-1:0]  lo_s [NUM_CS];
    logic [31:0]       rdata_q;
    logic              ctrl_wr;

    assign ctrl_wr = reg_wr_en && (reg_addr == '0);

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        assign start_s[c] = ctrl_wr && reg_wdata[CTRL_START_LSB + c];
        assign clear_s[c] = reg_rd_en && reg_addr[ADDR_W-1]
                            && (reg_addr[CS_W-1:0] == CS_W'(c));
        assign en_s[c]    = byte_valid && (byte_cs == CS_W'(c)) && mode_q[c];

        npp_context #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_s[c]),
            .clear_i   (clear_s[c]),
            .byte_en_i (en_s[c]),
            .data_i    (byte_data),
            .hi_o      (hi_s[c]),
            .lo_o      (lo_s[c])
        );
    end

    // Control register: load the NAND-mode bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (ctrl_wr) mode_q <= reg_wdata[CTRL_MODE_LSB +: NUM_CS];
    end

    // Read path: register the selected word, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= '0;
            if (reg_rd_en) begin
                if (reg_addr == '0) begin
                    rdata_q <= 32'(mode_q);
                end else if (reg_addr[ADDR_W-1]) begin
                    for (int c = 0; c < NUM_CS; c++) begin
                        if (reg_addr[CS_W-1:0] == CS_W'(c))
                            rdata_q <= pack_result(12'(hi_s[c]), 12'(lo_s[c]));
                    end
                end
            end
        end
    end

    assign reg_rdata = rdata_q;

    // R6
    rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:28] == 4'h0 && reg_rdata[15:12] == 4'h0));

    // R7
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> (reg_rdata == 32'h0));

    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (mode_q == $past(reg_wdata[NUM_CS-1:0])));
endmodule

// File: tb/nand_page_parity_test.sv
module nand_page_parity_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        byte_valid = 1'b0;
    logic [1:0]  byte_cs = '0;
    logic [7:0]  byte_data = '0;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] bufa [520];
    logic [7:0] bufb [520];

    always #4 clk = ~clk;

    nand_page_parity uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .byte_valid(byte_valid), .byte_cs(byte_cs), .byte_data(byte_data)
    );

    // Reference parity over buffer a (sel=0) or b (sel=1), first n bytes.
    function automatic logic [31:0] ref_word(input bit sel, input int n);
        logic [11:0] hi = '0, lo = '0, pos;
        logic [7:0]  d;
        for (int i = 0; i < n && i < 512; i++) begin
            d = sel ? bufb[i] : bufa[i];
            for (int j = 0; j < 8; j++) begin
                if (d[j]) begin
                    pos = {i[8:0], j[2:0]};
                    for (int k = 0; k < 12; k++) begin
                        if (pos[k]) hi[k] = ~hi[k];
                        else        lo[k] = ~lo[k];
                    end
                end
            end
        end
        return {4'h0, hi, 4'h0, lo};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd_en = 1'b0; v = reg_rdata;
    endtask

    task automatic send(input logic [1:0] cs, input bit sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_valid = 1'b1; byte_cs = cs;
            byte_data = sel ? bufb[i] : bufa[i];
        end
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic fill(input bit sel, input bit ones);
        for (int i = 0; i < 520; i++) begin
            if (sel) bufb[i] = ones ? 8'hFF : 8'($urandom);
            else     bufa[i] = ones ? 8'hFF : 8'($urandom);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, g1, g2;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd0, v); check("R1 ctrl", v, 32'h0);
        for (int c = 0; c < 4; c++) begin rd(3'(4 + c), v); check("R1 result", v, 32'h0); end

        // R2: mode readback, start bits not visible
        wr(3'd0, 32'h0000_000F); rd(3'd0, v); check("R2 mode", v, 32'hF);
        wr(3'd0, 32'h0000_010F); rd(3'd0, v); check("R2 start hidden", v, 32'hF);
        rd(3'd4, v);

        // R5/R6: random chunk on cs0
        fill(0, 0);
        wr(3'd0, 32'h0000_010F); send(2'd0, 0, 512);
        rd(3'd4, v); check("R5 R6 random cs0", v, ref_word(0, 512));
        // R7: second read is zero
        rd(3'd4, v); check("R7 clear on read", v, 32'h0);

        // R4: cs1 not armed
        send(2'd1, 0, 40); rd(3'd5, v); check("R4 unarmed", v, 32'h0);
        // R4: cs1 armed but NAND mode off
        wr(3'd0, 32'h0000_020D); send(2'd1, 0, 40); rd(3'd5, v); check("R4 mode off", v, 32'h0);

        // R3: interleaved cs2/cs3, partial chunks, start of one leaves other alone
        fill(0, 0); fill(1, 0);
        wr(3'd0, 32'h0000_040F);
        send(2'd2, 0, 100);
        wr(3'd0, 32'h0000_080F);
        for (int i = 0; i < 77; i++) begin
            @(negedge clk); byte_valid = 1'b1; byte_cs = 2'd3; byte_data = bufb[i];
            @(negedge clk); byte_cs = 2'd2; byte_data = bufa[100 + i];
        end
        @(negedge clk); byte_valid = 1'b0;
        rd(3'd6, v); check("R3 R5 cs2 interleaved", v, ref_word(0, 177));
        rd(3'd7, v); check("R3 R5 cs3 interleaved", v, ref_word(1, 77));

        // R8: erased chunk
        fill(0, 1);
        wr(3'd0, 32'h0000_010F); send(2'd0, 0, 512);
        rd(3'd4, v); check("R8 all ones", v, 32'h0);

        // R9: overflow beyond 512
        fill(0, 0);
        wr(3'd0, 32'h0000_080F); send(2'd3, 0, 520);
        rd(3'd7, v); check("R9 saturate", v, ref_word(0, 512));

        // R10: single-bit flips
        for (int t = 0; t < 4; t++) begin
            int bi, bj;
            fill(0, 0);
            for (int i = 0; i < 512; i++) bufb[i] = bufa[i];
            bi = (t == 0) ? 0 : (t == 1) ? 511 : int'($urandom_range(511));
            bj = (t == 0) ? 0 : (t == 1) ? 7 : int'($urandom_range(7));
            bufb[bi][bj] = ~bufb[bi][bj];
            wr(3'd0, 32'h0000_020F); send(2'd1, 0, 512); rd(3'd5, g1);
            wr(3'd0, 32'h0000_020F); send(2'd1, 1, 512); rd(3'd5, g2);
            check("R10 flipped ref", g2, ref_word(1, 512));
            v = g1 ^ g2;
            check("R10 position", {20'h0, v[27:16]}, {20'h0, bi[8:0], bj[2:0]});
            check("R10 complement", {20'h0, v[27:16] ^ v[11:0]}, 32'hFFF);
        end

        // R11: start in the same cycle as a byte drops the byte
        fill(0, 0);
        wr(3'd0, 32'h0000_040F);
        send(2'd2, 0, 3);
        @(negedge clk); reg_wr_en = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_040F;
        byte_valid = 1'b1; byte_cs = 2'd2; byte_data = 8'hA5;
        @(negedge clk); reg_wr_en = 1'b0; byte_valid = 1'b0;
        send(2'd2, 0, 5);
        rd(3'd6, v); check("R11 start drops byte", v, ref_word(0, 5));
        // R11: read in the same cycle as a byte drops the byte
        wr(3'd0, 32'h0000_040F); send(2'd2, 0, 5);
        @(negedge clk); reg_rd_en = 1'b1; reg_addr = 3'd6;
        byte_valid = 1'b1; byte_cs = 2'd2; byte_data = 8'h3C;
        @(negedge clk); reg_rd_en = 1'b0; byte_valid = 1'b0; v = reg_rdata;
        check("R11 read value", v, ref_word(0, 5));
        rd(3'd6, v); check("R11 read drops byte", v, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule